// File: doc/BRIEF.md
# Successive Approximation Converter Control

This block is the digital sequencer for an 8-bit successive approximation converter that sits behind a four-way analogue input multiplexer. With no trigger needed, it digitizes the chosen input over and over. Each conversion has a sampling stage, one trial per bit from the most significant down, and a transfer stage. The block drives the trial code to the converter's DAC and reads back a single comparator decision per bit. The analogue switches are driven by a sample phase and a conversion phase, and these two are never high together.

A host reads the latest finished code from a result register. It raises a read request while the read is under way. A result that completes during a read is held aside and goes into the register on the first clock after the read is released, so the register never changes under an active read. There is also a test mode in which the comparator is ignored and the DAC code ramps downward without end, so the ramp can be observed on the analogue side.

Top module: `sar_adc_ctrl`

## Requirements
- R1: The result equals the largest code whose DAC level does not exceed the input. Bits are tried from bit 7 down to bit 0. During the first clock of each trial, the DAC code holds the bits kept so far with the bit under trial set, so the first trial drives 0x80. A bit is kept when the comparator input is 1, meaning the input is at or above the trial level. The result puts the most significant bit at bit 7 and is not inverted.
- R2: A conversion takes exactly 20 clocks: 2 sampling clocks, 8 trials of 2 clocks each, then 2 transfer clocks. After reset is released, the first result is written on the 20th rising edge. Before that edge the result register keeps its reset value.
- R3: The sample phase is high only during the 2 sampling clocks. The conversion phase is high only during the 16 trial clocks. The two phases are never high at the same time.
- R4: The multiplexer select resets to 0. It loads the 2-bit input select only on the last clock of a conversion, so the next conversion uses the new input. The current-source enable is high exactly when the select is 3.
- R5: In normal mode, conversions run back to back with no trigger, and the result register always holds the latest completed code.
- R6: When the read request is high at the edge where a result would be written, the result register keeps its old value.
- R7: A result held back by R6 is written on the first clock edge at which the read request is low.
- R8: While test mode is high, the DAC code starts at 255 and falls by one on every clock, going from 0 back to 255. Both phases stay low and the result register is not updated. When test mode drops, a fresh conversion starts.
- R9: During reset, the result, DAC code, multiplexer select, current-source enable and conversion phase are all 0, and the sample phase is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| comp_i | input | 1 | Comparator decision, 1 when input is at or above the DAC level |
| in_sel_i | input | 2 | Requested analogue input |
| test_mode_i | input | 1 | 1 selects the DAC down-ramp |
| rd_req_i | input | 1 | High while the host reads the result |
| dac_code_o | output | 8 | Code driven to the DAC |
| mux_sel_o | output | 2 | Multiplexer select in use |
| phi_samp_o | output | 1 | Sampling switch phase |
| phi_conv_o | output | 1 | Conversion switch phase |
| cur_en_o | output | 1 | Current-source enable for input 3 |
| result_o | output | 8 | Latest stored conversion result |

## Verification
The hardest case to reach is a read that is already in progress at the exact edge where a conversion finishes. Only in that case does a result have to be parked and written later. The bench aligns to the edge where reset is released and counts clocks to the end of the second conversion. It raises the read request one clock before that edge and holds it for several clocks. It then checks that the old value stays in place, and that the new code appears one clock after the request drops. Test-mode wrap-around is reached by staying in test mode for a full 256-clock lap.

// File: rtl/sar_pkg.sv
// Shared types for the successive approximation converter control.
// Assumes nothing beyond the stage ordering sample -> trial -> transfer.
package sar_pkg;

    typedef enum logic [1:0] {
        STG_SAMPLE = 2'd0,
        STG_TRIAL  = 2'd1,
        STG_XFER   = 2'd2
    } stage_t;

endpackage

// File: rtl/sar_seq.sv
// Conversion sequencer: counts the clocks of one conversion and yields the
// stage, the current bit under trial, the decision strobe and the switch
// phases. Assumes TRIAL_CYC >= 1 and a synchronous active-low reset.
// Test mode holds the sequencer at the start of a conversion.
module sar_seq
    import sar_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int SAMPLE_CYC = 2,
    parameter int TRIAL_CYC  = 2,
    parameter int XFER_CYC   = 2,
    localparam int TOTAL     = SAMPLE_CYC + WIDTH * TRIAL_CYC + XFER_CYC,
    localparam int CW        = $clog2(TOTAL),
    localparam int BW        = (WIDTH > 1) ? $clog2(WIDTH) : 1,
    localparam int SUBW      = (TRIAL_CYC > 1) ? $clog2(TRIAL_CYC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_mode,
    output logic          start,
    output logic          decide,
    output logic [BW-1:0] bit_idx,
    output logic          conv_end,
    output logic          phi_samp,
    output logic          phi_conv
);

    localparam logic [CW-1:0]   LAST_C      = CW'(TOTAL - 1);
    localparam logic [CW-1:0]   TRIAL_BEG   = CW'(SAMPLE_CYC);
    localparam logic [CW-1:0]   TRIAL_END   = CW'(SAMPLE_CYC + WIDTH * TRIAL_CYC);
    localparam logic [CW-1:0]   LAST_SAMP   = CW'(SAMPLE_CYC - 1);
    localparam logic [SUBW-1:0] SUB_LAST    = SUBW'(TRIAL_CYC - 1);
    localparam logic [BW-1:0]   TOP_BIT     = BW'(WIDTH - 1);
    localparam logic [CW-1:0]   LAST_DECIDE = CW'(SAMPLE_CYC + WIDTH * TRIAL_CYC - 1);

    logic [CW-1:0]   cnt;
    logic [SUBW-1:0] sub;
    stage_t          stage;

    // Stage decode from the conversion counter.
    always_comb begin
        if (cnt < TRIAL_BEG)      stage = STG_SAMPLE;
        else if (cnt < TRIAL_END) stage = STG_TRIAL;
        else                      stage = STG_XFER;
    end

    // Overall clock counter for one conversion.
    always_ff @(posedge clk) begin
        if (!rst_n || test_mode) cnt <= '0;
        else if (cnt == LAST_C)  cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    // Clock-within-trial counter; a single-clock trial needs none.
    generate
        if (TRIAL_CYC > 1) begin : g_sub
            always_ff @(posedge clk) begin
                if (!rst_n || test_mode)  sub <= '0;
                else if (stage == STG_TRIAL) sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
            end
        end else begin : g_nosub
            assign sub = '0;
        end
    endgenerate

    // Bit under trial, walking from the top bit down.
    always_ff @(posedge clk) begin
        if (!rst_n || test_mode) bit_idx <= TOP_BIT;
        else if (decide)          bit_idx <= (bit_idx == '0) ? TOP_BIT : bit_idx - 1'b1;
    end

    // Strobes and switch phases.
    always_comb begin
        start    = (cnt == LAST_SAMP) && !test_mode;
        decide   = (stage == STG_TRIAL) && (sub == SUB_LAST) && !test_mode;
        conv_end = (cnt == LAST_C) && !test_mode;
        phi_samp = (stage == STG_SAMPLE) && !test_mode;
        phi_conv = (stage == STG_TRIAL) && !test_mode;
    end

    a_r3_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(phi_samp && phi_conv));

    a_r2_wrap_to_sample: assert property (@(posedge clk) disable iff (!rst_n)
        conv_end |=> (stage == STG_SAMPLE));

    a_r2_last_bit_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && bit_idx == '0) |-> (cnt == LAST_DECIDE));

endmodule

// File: rtl/sar_core.sv
// Trial register and test ramp. Keeps or clears each trial bit from the
// comparator and sets the next lower bit; in test mode a down-counter
// replaces the trial code on the DAC. Assumes start and decide never coincide.
module sar_core #(
    parameter int WIDTH = 8,
    localparam int BW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic             start,
    input  logic             decide,
    input  logic [BW-1:0]    bit_idx,
    input  logic             comp,
    output logic [WIDTH-1:0] trial,
    output logic [WIDTH-1:0] dac_code
);

    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] TOPM = ONE << (WIDTH - 1);

    logic [WIDTH-1:0] ramp;
    logic [WIDTH-1:0] cur_mask;
    logic [WIDTH-1:0] nxt_mask;

    // Masks for the bit being decided and the one tried next.
    always_comb begin
        cur_mask = ONE << bit_idx;
        nxt_mask = (bit_idx == '0) ? '0 : (ONE << (bit_idx - 1'b1));
    end

    // Successive approximation register.
    always_ff @(posedge clk) begin
        if (!rst_n)      trial <= '0;
        else if (start)  trial <= TOPM;
        else if (decide) trial <= (comp ? trial : (trial & ~cur_mask)) | nxt_mask;
    end

    // Test-mode down ramp, parked at full scale when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_mode) ramp <= '1;
        else                      ramp <= ramp - 1'b1;
    end

    // DAC code source select.
    always_comb dac_code = test_mode ? ramp : trial;

    a_r8_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && ramp != '0) |=> (!test_mode || ramp == $past(ramp) - 1'b1));

    a_r1_bit_cleared_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !comp && bit_idx == '0) |=> !trial[0]);

endmodule

// File: rtl/sar_result.sv
// Result register with read interlock. A write arriving while a read is
// active is parked and applied on the first clock with no read.
// Assumes wr_en is a one-clock strobe.
module sar_result #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    output logic [WIDTH-1:0] result
);

    logic             pending;
    logic [WIDTH-1:0] pend_data;

    // Write, park, or drain the parked value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            pending   <= 1'b0;
            pend_data <= '0;
        end else if (wr_en) begin
            if (rd_req) begin
                pending   <= 1'b1;
                pend_data <= wr_data;
            end else begin
                result  <= wr_data;
                pending <= 1'b0;
            end
        end else if (pending && !rd_req) begin
            result  <= pend_data;
            pending <= 1'b0;
        end
    end

    a_r6_read_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> $stable(result));

    a_r7_pending_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !rd_req && !wr_en) |=> (result == $past(pend_data)));

endmodule

// File: rtl/sar_adc_ctrl.sv
// Top of the successive approximation converter control. Ties sequencer,
// trial register and result register together and owns the input select.
// Assumes a free-running clock and a comparator settled within one trial.
module sar_adc_ctrl #(
    parameter int WIDTH      = 8,
    parameter int NUM_IN     = 4,
    parameter int SAMPLE_CYC = 2,
    parameter int TRIAL_CYC  = 2,
    parameter int XFER_CYC   = 2,
    parameter int CUR_SRC_IN = 3,
    localparam int SELW      = $clog2(NUM_IN),
    localparam int BW        = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             comp_i,
    input  logic [SELW-1:0]  in_sel_i,
    input  logic             test_mode_i,
    input  logic             rd_req_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic [SELW-1:0]  mux_sel_o,
    output logic             phi_samp_o,
    output logic             phi_conv_o,
    output logic             cur_en_o,
    output logic [WIDTH-1:0] result_o
);

    localparam logic [SELW-1:0] CUR_SEL = SELW'(CUR_SRC_IN);

    logic          start;
    logic          decide;
    logic [BW-1:0] bit_idx;
    logic          conv_end;
    logic [WIDTH-1:0] trial;

    sar_seq #(
        .WIDTH(WIDTH), .SAMPLE_CYC(SAMPLE_CYC),
        .TRIAL_CYC(TRIAL_CYC), .XFER_CYC(XFER_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode_i),
        .start(start), .decide(decide), .bit_idx(bit_idx),
        .conv_end(conv_end), .phi_samp(phi_samp_o), .phi_conv(phi_conv_o)
    );

    sar_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode_i),
        .start(start), .decide(decide), .bit_idx(bit_idx),
        .comp(comp_i), .trial(trial), .dac_code(dac_code_o)
    );

    sar_result #(.WIDTH(WIDTH)) u_res (
        .clk(clk), .rst_n(rst_n), .wr_en(conv_end),
        .wr_data(trial), .rd_req(rd_req_i), .result(result_o)
    );

    // Input select changes only between conversions.
    always_ff @(posedge clk) begin
        if (!rst_n)        mux_sel_o <= '0;
        else if (conv_end) mux_sel_o <= in_sel_i;
    end

    // Current source follows the selected input.
    always_comb cur_en_o = (mux_sel_o == CUR_SEL);

    a_r4_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_end |=> $stable(mux_sel_o));

endmodule

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/1ps
module sim_sar_adc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       comp;
    logic [1:0] in_sel = 2'd0;
    logic       test_mode = 1'b0;
    logic       rd_req = 1'b0;
    logic [7:0] dac_code;
    logic [1:0] mux_sel;
    logic       phi_samp, phi_conv, cur_en;
    logic [7:0] result;
    logic [7:0] vin [4];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // Comparator model: 1 when the selected input is at or above the DAC level.
    assign comp = (vin[mux_sel] >= dac_code);

    sar_adc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .comp_i(comp), .in_sel_i(in_sel),
        .test_mode_i(test_mode), .rd_req_i(rd_req), .dac_code_o(dac_code),
        .mux_sel_o(mux_sel), .phi_samp_o(phi_samp), .phi_conv_o(phi_conv),
        .cur_en_o(cur_en), .result_o(result)
    );

    // Vector table: {input select, input code}.
    localparam logic [9:0] VEC [8] = '{
        {2'd0, 8'h00}, {2'd0, 8'hFF}, {2'd1, 8'h80}, {2'd2, 8'h7F},
        {2'd3, 8'h01}, {2'd1, 8'hA5}, {2'd3, 8'hFE}, {2'd2, 8'h3C}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 4; k++) vin[k] = 8'h00;
        vin[0] = 8'h5A;

        // R9 reset state
        repeat (3) @(negedge clk);
        chk("R9 result", result, 8'h00);
        chk("R9 dac", dac_code, 8'h00);
        chk("R9 mux_sel", mux_sel, 2'd0);
        chk("R9 cur_en", cur_en, 1'b0);
        chk("R9 phi_samp", phi_samp, 1'b1);
        chk("R9 phi_conv", phi_conv, 1'b0);

        // R2 R3 R1 first conversion, aligned to reset release
        rst_n = 1'b1;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            chk("R3 phi_samp", phi_samp, ((i % 20) < 2));
            chk("R3 phi_conv", phi_conv, ((i % 20) >= 2 && (i % 20) < 18));
            if (i == 2)  chk("R1 first trial code", dac_code, 8'h80);
            if (i == 4)  chk("R1 second trial code", dac_code, 8'h40);
            if (i == 6)  chk("R1 third trial code", dac_code, 8'h60);
            if (i == 19) chk("R2 not yet written", result, 8'h00);
            if (i == 20) chk("R2 written at edge 20", result, 8'h5A);
        end

        // R6 R7 read interlock at the end of the second conversion
        vin[0] = 8'h33;
        repeat (19) @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        chk("R6 blocked at write edge", result, 8'h5A);
        @(negedge clk);
        chk("R6 still blocked", result, 8'h5A);
        @(negedge clk);
        chk("R6 still blocked late", result, 8'h5A);
        rd_req = 1'b0;
        @(negedge clk);
        chk("R7 parked result written", result, 8'h33);

        // R8 test mode ramp
        vin[0] = 8'h11;
        test_mode = 1'b1;
        #1;
        chk("R8 ramp start", dac_code, 8'hFF);
        @(negedge clk);
        chk("R8 ramp step", dac_code, 8'hFE);
        chk("R8 samp low", phi_samp, 1'b0);
        chk("R8 conv low", phi_conv, 1'b0);
        repeat (254) @(negedge clk);
        chk("R8 ramp reaches zero", dac_code, 8'h00);
        @(negedge clk);
        chk("R8 ramp wraps", dac_code, 8'hFF);
        chk("R8 result not updated", result, 8'h33);
        test_mode = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 fresh conversion after test", result, 8'h11);

        // R1 R4 R5 table of inputs and selects
        for (int v = 0; v < 8; v++) begin
            in_sel = VEC[v][9:8];
            vin[VEC[v][9:8]] = VEC[v][7:0];
            repeat (41) @(negedge clk);
            chk("R1 R5 result", result, VEC[v][7:0]);
            chk("R4 mux_sel", mux_sel, VEC[v][9:8]);
            chk("R4 cur_en", cur_en, (VEC[v][9:8] == 2'd3));
        end

        finish_run();
    end

endmodule